// File: doc/BRIEF.md
# Display FIFO Watermark Calculator

This block works out the two timing words a CRT controller needs to refill its display FIFO from video memory. One word holds the thresholds at which refill requests turn on and off. The other holds the arithmetic precision, the loop latency and the number of memory clocks per FIFO word. The inputs are a set of clock-divider settings and memory timing figures. From these the block forms a ratio of memory clock to pixel clock. It picks a fixed-point precision that suits the size of that ratio, then scales, rounds and clamps the thresholds.

Software or a mode-set sequencer presents one full set of inputs with a valid/ready handshake on the request side. `in_ready` is high only while the block is idle. An input set is taken on the clock edge where `in_valid` and `in_ready` are both high. While the block is computing, `in_ready` stays low, and `in_valid` and the input bus are ignored.

On the result side, `out_valid` rises when both words are ready. It stays high, with both words held steady, until the consumer raises `out_ready`. If `out_ready` is tied high, `out_valid` is a single-cycle done pulse. All divisions run one after another on a single serial restoring divider.

Top module: `wm_fifo_watermark`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. An input set is captured on the edge where `in_valid` and `in_ready` are both high, and `in_ready` is low on the following cycle. While busy, changes on `in_valid` or on the input bus have no effect on the result.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and both output words stay stable. After an edge with `out_valid` and `out_ready` both high, `out_valid` is low and `in_ready` is high.
- R3: `out_valid` rises exactly 4*(DW+2) clock edges after the accepting edge, which is 136 edges with the defaults.
- R4: Ratio terms. M is `mem_fb` * `pix_post`. D is `pix_fb` * `mem_ref`, further multiplied by `bpp`>>2 when `bpp` >= 8. Then M and D are both halved, repeatedly, for as long as both are even.
- R5: The base shift S0 is 4 - `mem_pcode`, reduced by one more when `bpp` is 0.
- R6: Let Q1 = ((M * `fifo_depth`) << S0) / D. The precision P is the bit length of Q1 minus 5, clamped to 0..7, and it sits in `cfg_word` bits 22:20. Let X = 6 - P. Let S = S0 + X. A shift left by a negative amount means a shift right by that amount's magnitude.
- R7: The off threshold is OFF = ((M * (`fifo_depth` - 1)) << S) / D - (1 << S0), in 32-bit modular arithmetic.
- R8: Let Q4 = (M << S) / D and R = (`ras_dly` << X) + 1. The raw on threshold is max(Q4 + 1, R) + 2R + (`pf_dly` << X).
- R9: The granule is G = 2^(6-P) for P <= 6 and G = 1 for P = 7. The on threshold is rounded up to a multiple of G.
- R10: If the rounded on threshold is at least OFF rounded down to a multiple of G, the on threshold becomes (OFF - Q4) rounded down to a multiple of G.
- R11: The clocks-per-word value is ((M << (S+5)) + D) / D, and it is ORed into `cfg_word` from bit 0.
- R12: `on_off_word` = (ON << 16) + OFF modulo 2^32. `cfg_word` = (P << 20) | (`loop_lat` << 16) | clocks-per-word.
- R13: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set valid |
| in_ready | output | 1 | Block idle, input set can be taken |
| mem_fb | input | FBW | Memory clock feedback divider |
| pix_fb | input | FBW | Pixel clock feedback divider |
| pix_post | input | 4 | Pixel clock post divider, real value |
| mem_ref | input | 2 | Memory clock reference divider (1 or 3) |
| mem_pcode | input | 2 | Memory clock post divider code |
| bpp | input | BPPW | Bits per pixel, 0 selects the narrow-FIFO mode |
| fifo_depth | input | DEPW | Display FIFO depth in words |
| ras_dly | input | DLYW | Maximum RAS delay in memory clocks |
| pf_dly | input | DLYW | Page-fault delay in memory clocks |
| loop_lat | input | LATW | Loop latency field |
| out_valid | output | 1 | Result words valid |
| out_ready | input | 1 | Consumer accepts the result |
| on_off_word | output | DW | Packed on/off threshold word |
| cfg_word | output | DW | Packed precision, latency and clocks-per-word word |

## Verification
The bench builds the block with the default parameters: a 32-bit datapath, 8-bit feedback dividers, 6-bit depth and bpp fields, and 4-bit delay and latency fields. The sweep covers every post-divider code, all five pixel post dividers, bpp values 0, 4, 8, 16 and 32, both reference dividers, FIFO depths of 24 and 32, and several divider pairs. That range drives the precision into both clamps and the on threshold into its fall-back branch. It also exercises the right shift that occurs at the top precision, and holds the result while the consumer stalls.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int WM_DW    = 32;
  localparam int WM_FBW   = 8;
  localparam int WM_BPPW  = 6;
  localparam int WM_DEPW  = 6;
  localparam int WM_DLYW  = 4;
  localparam int WM_LATW  = 4;
  localparam int WM_POSTW = 4;
  localparam int WM_REFW  = 2;
  localparam int WM_PCW   = 2;
  localparam int WM_ONPOS   = 16;
  localparam int WM_LATPOS  = 16;
  localparam int WM_PRECPOS = 20;
  localparam int WM_PMAX    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_Q1,
    ST_Q2,
    ST_Q4,
    ST_Q5,
    ST_DONE
  } wm_state_e;
endpackage

// File: rtl/wm_prep.sv
module wm_prep #(
  parameter int DW    = wm_pkg::WM_DW,
  parameter int FBW   = wm_pkg::WM_FBW,
  parameter int BPPW  = wm_pkg::WM_BPPW,
  parameter int DEPW  = wm_pkg::WM_DEPW,
  parameter int POSTW = wm_pkg::WM_POSTW,
  parameter int REFW  = wm_pkg::WM_REFW,
  parameter int PCW   = wm_pkg::WM_PCW
) (
  input  logic [FBW-1:0]   mem_fb,
  input  logic [FBW-1:0]   pix_fb,
  input  logic [POSTW-1:0] pix_post,
  input  logic [REFW-1:0]  mem_ref,
  input  logic [PCW-1:0]   mem_pcode,
  input  logic [BPPW-1:0]  bpp,
  input  logic [DEPW-1:0]  fifo_depth,
  output logic [DW-1:0]    mult,
  output logic [DW-1:0]    dvs,
  output logic [2:0]       base_sh,
  output logic [DW-1:0]    num1
);
  logic [DW-1:0] m_raw, d_raw, both;
  int tz;
  logic seen;

  always_comb begin
    m_raw = DW'(mem_fb) * DW'(pix_post);
    d_raw = DW'(pix_fb) * DW'(mem_ref);
    if (bpp >= BPPW'(8)) d_raw = d_raw * DW'(bpp >> 2);

    base_sh = 3'd4 - 3'(mem_pcode);
    if (bpp == '0) base_sh = base_sh - 3'd1;

    both = m_raw | d_raw;
    tz   = 0;
    seen = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (!seen && both[i]) begin
        tz   = i;
        seen = 1'b1;
      end
    end
    mult = m_raw >> tz;
    dvs  = d_raw >> tz;
    num1 = (mult * DW'(fifo_depth)) << base_sh;
  end
endmodule

// File: rtl/wm_div.sv
module wm_div #(
  parameter int DW = wm_pkg::WM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, quo_q, rem_n, quo_n;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial, diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[DW-1]};
    diff  = trial - {1'b0, den};
    fits  = (trial >= {1'b0, den});
    rem_n = fits ? diff[DW-1:0] : trial[DW-1:0];
    quo_n = {quo_q[DW-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        rem_q <= '0;
        quo_q <= num;
        cnt_q <= CW'(DW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quo = quo_q;
endmodule

// File: rtl/wm_shape.sv
module wm_shape #(
  parameter int DW   = wm_pkg::WM_DW,
  parameter int DEPW = wm_pkg::WM_DEPW,
  parameter int DLYW = wm_pkg::WM_DLYW,
  parameter int LATW = wm_pkg::WM_LATW
) (
  input  logic [DW-1:0]   mult,
  input  logic [DW-1:0]   dvs,
  input  logic [2:0]      base_sh,
  input  logic [DEPW-1:0] fifo_depth,
  input  logic [DLYW-1:0] ras_dly,
  input  logic [DLYW-1:0] pf_dly,
  input  logic [LATW-1:0] loop_lat,
  input  logic [DW-1:0]   q1,
  input  logic [DW-1:0]   q2,
  input  logic [DW-1:0]   q4,
  input  logic [DW-1:0]   q5,
  output logic [DW-1:0]   num2,
  output logic [DW-1:0]   num4,
  output logic [DW-1:0]   num5,
  output logic [DW-1:0]   on_off,
  output logic [DW-1:0]   cfg
);
  import wm_pkg::*;

  function automatic logic [DW-1:0] sh_s(input logic [DW-1:0] v, input int a);
    if (a >= 0) return v << a;
    else        return v >> (-a);
  endfunction

  int bl, prec, xs, shf, gexp;
  logic [DW-1:0] off, rr, lo, on0, msk, on_up, off_dn, on_f;

  always_comb begin
    bl = 0;
    for (int i = 0; i < DW; i++) if (q1[i]) bl = i + 1;
    if (bl <= 5)                 prec = 0;
    else if (bl - 5 > WM_PMAX)   prec = WM_PMAX;
    else                         prec = bl - 5;

    xs  = 6 - prec;
    shf = int'(base_sh) + xs;

    num2 = sh_s(mult * (DW'(fifo_depth) - DW'(1)), shf);
    num4 = sh_s(mult, shf);
    num5 = sh_s(mult, shf + 5) + dvs;

    off = q2 - (DW'(1) << base_sh);
    rr  = sh_s(DW'(ras_dly), xs) + DW'(1);
    lo  = q4 + DW'(1);
    on0 = ((lo > rr) ? lo : rr) + (rr << 1) + sh_s(DW'(pf_dly), xs);

    gexp   = (prec == WM_PMAX) ? 0 : 6 - prec;
    msk    = (DW'(1) << gexp) - DW'(1);
    on_up  = (on0 + msk) & ~msk;
    off_dn = off & ~msk;
    on_f   = (on_up >= off_dn) ? ((off - q4) & ~msk) : on_up;

    on_off = (on_f << WM_ONPOS) + off;
    cfg    = (DW'(prec) << WM_PRECPOS) | (DW'(loop_lat) << WM_LATPOS) | q5;
  end
endmodule

// File: rtl/wm_fifo_watermark.sv
module wm_fifo_watermark #(
  parameter int DW    = wm_pkg::WM_DW,
  parameter int FBW   = wm_pkg::WM_FBW,
  parameter int BPPW  = wm_pkg::WM_BPPW,
  parameter int DEPW  = wm_pkg::WM_DEPW,
  parameter int DLYW  = wm_pkg::WM_DLYW,
  parameter int LATW  = wm_pkg::WM_LATW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [FBW-1:0]                mem_fb,
  input  logic [FBW-1:0]                pix_fb,
  input  logic [wm_pkg::WM_POSTW-1:0]   pix_post,
  input  logic [wm_pkg::WM_REFW-1:0]    mem_ref,
  input  logic [wm_pkg::WM_PCW-1:0]     mem_pcode,
  input  logic [BPPW-1:0]               bpp,
  input  logic [DEPW-1:0]               fifo_depth,
  input  logic [DLYW-1:0]               ras_dly,
  input  logic [DLYW-1:0]               pf_dly,
  input  logic [LATW-1:0]               loop_lat,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DW-1:0]                 on_off_word,
  output logic [DW-1:0]                 cfg_word
);
  import wm_pkg::*;

  wm_state_e state;

  logic [FBW-1:0]      c_mfb, c_pfb;
  logic [WM_POSTW-1:0] c_post;
  logic [WM_REFW-1:0]  c_ref;
  logic [WM_PCW-1:0]   c_pc;
  logic [BPPW-1:0]     c_bpp;
  logic [DEPW-1:0]     c_dep;
  logic [DLYW-1:0]     c_ras, c_pf;
  logic [LATW-1:0]     c_lat;

  logic [DW-1:0] q1_r, q2_r, q4_r, oo_r, cf_r;
  logic [DW-1:0] mult, dvs, num1, num2, num4, num5, dnum, quo, oo_n, cf_n;
  logic [2:0]    base_sh;
  logic          busy, fin, go, in_div;

  wm_prep #(.DW(DW), .FBW(FBW), .BPPW(BPPW), .DEPW(DEPW),
            .POSTW(WM_POSTW), .REFW(WM_REFW), .PCW(WM_PCW)) u_prep (
    .mem_fb(c_mfb), .pix_fb(c_pfb), .pix_post(c_post), .mem_ref(c_ref),
    .mem_pcode(c_pc), .bpp(c_bpp), .fifo_depth(c_dep),
    .mult(mult), .dvs(dvs), .base_sh(base_sh), .num1(num1)
  );

  wm_shape #(.DW(DW), .DEPW(DEPW), .DLYW(DLYW), .LATW(LATW)) u_shape (
    .mult(mult), .dvs(dvs), .base_sh(base_sh), .fifo_depth(c_dep),
    .ras_dly(c_ras), .pf_dly(c_pf), .loop_lat(c_lat),
    .q1(q1_r), .q2(q2_r), .q4(q4_r), .q5(quo),
    .num2(num2), .num4(num4), .num5(num5), .on_off(oo_n), .cfg(cf_n)
  );

  wm_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .num(dnum), .den(dvs),
    .busy(busy), .fin(fin), .quo(quo)
  );

  always_comb begin
    in_div = (state == ST_Q1) || (state == ST_Q2) ||
             (state == ST_Q4) || (state == ST_Q5);
    go = in_div && !busy && !fin;
    unique case (state)
      ST_Q2:   dnum = num2;
      ST_Q4:   dnum = num4;
      ST_Q5:   dnum = num5;
      default: dnum = num1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      c_mfb  <= '0;
      c_pfb  <= '0;
      c_post <= '0;
      c_ref  <= '0;
      c_pc   <= '0;
      c_bpp  <= '0;
      c_dep  <= '0;
      c_ras  <= '0;
      c_pf   <= '0;
      c_lat  <= '0;
      q1_r   <= '0;
      q2_r   <= '0;
      q4_r   <= '0;
      oo_r   <= '0;
      cf_r   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          c_mfb  <= mem_fb;
          c_pfb  <= pix_fb;
          c_post <= pix_post;
          c_ref  <= mem_ref;
          c_pc   <= mem_pcode;
          c_bpp  <= bpp;
          c_dep  <= fifo_depth;
          c_ras  <= ras_dly;
          c_pf   <= pf_dly;
          c_lat  <= loop_lat;
          state  <= ST_Q1;
        end
        ST_Q1: if (fin) begin
          q1_r  <= quo;
          state <= ST_Q2;
        end
        ST_Q2: if (fin) begin
          q2_r  <= quo;
          state <= ST_Q4;
        end
        ST_Q4: if (fin) begin
          q4_r  <= quo;
          state <= ST_Q5;
        end
        ST_Q5: if (fin) begin
          oo_r  <= oo_n;
          cf_r  <= cf_n;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_DONE);
  assign on_off_word = oo_r;
  assign cfg_word    = cf_r;
endmodule

// File: rtl/wm_fifo_watermark_chk.sv
module wm_fifo_watermark_chk #(
  parameter int DW = wm_pkg::WM_DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] on_off_word,
  input logic [DW-1:0] cfg_word
);
  localparam int LAT = 4 * (DW + 2);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_cnt <= '0;
    else if (in_valid && in_ready) run_cnt <= 16'd1;
    else if (!in_ready && !out_valid) run_cnt <= run_cnt + 16'd1;
  end

  a_r1_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(on_off_word) && $stable(cfg_word)));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (run_cnt == 16'(LAT + 1)));
endmodule

bind wm_fifo_watermark wm_fifo_watermark_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .on_off_word(on_off_word), .cfg_word(cfg_word)
);

// File: tb/wm_fifo_watermark_tb.sv
module wm_fifo_watermark_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  mem_fb, pix_fb;
  logic [3:0]  pix_post;
  logic [1:0]  mem_ref, mem_pcode;
  logic [5:0]  bpp, fifo_depth;
  logic [3:0]  ras_dly, pf_dly, loop_lat;
  logic [31:0] on_off_word, cfg_word;

  int checks = 0;
  int errors = 0;

  wm_fifo_watermark u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mem_fb(mem_fb), .pix_fb(pix_fb), .pix_post(pix_post), .mem_ref(mem_ref),
    .mem_pcode(mem_pcode), .bpp(bpp), .fifo_depth(fifo_depth),
    .ras_dly(ras_dly), .pf_dly(pf_dly), .loop_lat(loop_lat),
    .out_valid(out_valid), .out_ready(out_ready),
    .on_off_word(on_off_word), .cfg_word(cfg_word)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] shl(input logic [31:0] v, input int a);
    return (a >= 0) ? (v << a) : (v >> (-a));
  endfunction

  function automatic void model(
    input int fbm, input int fbp, input int pr, input int rf, input int pc,
    input int bp, input int dp, input int ras, input int pf, input int lat,
    output logic [31:0] w_oo, output logic [31:0] w_cf, output bit clamped);
    logic [31:0] m, d, t, off, q4, r, on, g, xc;
    int base, bl, prec, xs, sh;
    m = 32'(fbm * pr);
    d = 32'(fbp * rf);
    if (bp >= 8) d = d * 32'(bp / 4);
    base = 4 - pc;
    if (bp == 0) base = base - 1;
    while (((m | d) & 32'd1) == 32'd0) begin
      m = m / 2;
      d = d / 2;
    end
    t = ((m * 32'(dp)) << base) / d;
    bl = 0;
    while (t != 0) begin
      t = t / 2;
      bl++;
    end
    prec = bl - 5;
    if (prec < 0) prec = 0;
    if (prec > 7) prec = 7;
    xs = 6 - prec;
    sh = base + xs;
    off = shl(m * 32'(dp - 1), sh) / d - (32'd1 << base);
    q4  = shl(m, sh) / d;
    r   = shl(32'(ras), xs) + 32'd1;
    on  = (((q4 + 1) > r) ? (q4 + 1) : r) + 2 * r + shl(32'(pf), xs);
    g   = (((32'd1 << (7 - prec)) - 32'd1) >> 1) + 32'd1;
    on  = ((on + g - 32'd1) / g) * g;
    clamped = 1'b0;
    if (on >= (off / g) * g) begin
      on = ((off - q4) / g) * g;
      clamped = 1'b1;
    end
    xc = (shl(m, sh + 5) + d) / d;
    w_oo = (on << 16) + off;
    w_cf = (32'(prec) << 20) | (32'(lat) << 16) | xc;
  endfunction

  task automatic run_one(input int fbm, input int fbp, input int pr, input int rf,
                         input int pc, input int bp, input int dp, input int ras,
                         input int pf, input int lat, input bit hold, input bit noise);
    logic [31:0] e_oo, e_cf;
    bit clamped;
    int cyc;
    model(fbm, fbp, pr, rf, pc, bp, dp, ras, pf, lat, e_oo, e_cf, clamped);
    @(negedge clk);
    mem_fb = 8'(fbm); pix_fb = 8'(fbp); pix_post = 4'(pr); mem_ref = 2'(rf);
    mem_pcode = 2'(pc); bpp = 6'(bp); fifo_depth = 6'(dp);
    ras_dly = 4'(ras); pf_dly = 4'(pf); loop_lat = 4'(lat);
    out_ready = !hold;
    in_valid = 1'b1;
    chk(32'(in_ready), 32'd1, "R1 ready before accept");
    @(posedge clk); #1;
    in_valid = noise;
    if (noise) begin
      mem_fb = ~mem_fb; pix_fb = 8'd129; pix_post = 4'd1; mem_pcode = ~mem_pcode;
      bpp = 6'd0; fifo_depth = 6'd9; ras_dly = ~ras_dly; loop_lat = ~loop_lat;
    end
    cyc = 0;
    while (!out_valid && cyc < 1000) begin
      if (noise && cyc == 5) chk(32'(in_ready), 32'd0, "R1 busy blocks intake");
      if (cyc == 100) in_valid = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    chk(32'(cyc), 32'd136, "R3 latency");
    chk(on_off_word, e_oo, "R4 R5 R7 R8 R9 on/off word");
    chk(cfg_word, e_cf, "R6 R11 R12 config word");
    if (clamped) chk(on_off_word, e_oo, "R10 on threshold fall-back");
    if (hold) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #1;
        chk(32'(out_valid), 32'd1, "R2 valid held");
        chk(on_off_word, e_oo, "R2 on/off stable");
        chk(cfg_word, e_cf, "R2 config stable");
      end
      out_ready = 1'b1;
    end
    @(posedge clk); #1;
    chk(32'(in_ready), 32'd1, "R2 idle after handshake");
    chk(32'(out_valid), 32'd0, "R2 valid dropped");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    int posts[5];
    int bpps[5];
    int mfbs[3];
    int pfbs[3];
    posts = '{1, 2, 4, 8, 3};
    bpps  = '{0, 4, 8, 16, 32};
    mfbs  = '{150, 255, 192};
    pfbs  = '{200, 128, 160};
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    mem_fb = '0; pix_fb = '0; pix_post = '0; mem_ref = '0; mem_pcode = '0;
    bpp = '0; fifo_depth = '0; ras_dly = '0; pf_dly = '0; loop_lat = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(32'(in_ready), 32'd1, "R13 reset ready");
    chk(32'(out_valid), 32'd0, "R13 reset valid");
    rst_n = 1'b1;
    idx = 0;
    for (int pc = 0; pc < 4; pc++)
      for (int bi = 0; bi < 5; bi++)
        for (int pi = 0; pi < 5; pi++)
          for (int fi = 0; fi < 3; fi++) begin
            run_one(mfbs[fi], pfbs[fi], posts[pi], (idx % 3 == 0) ? 3 : 1, pc,
                    bpps[bi], (idx % 2 == 0) ? 24 : 32, 2 + idx % 5, 3 + idx % 7,
                    idx % 16, (idx % 7 == 3), (idx % 11 == 5));
            idx++;
          end
    run_one(128, 255, 1, 3, 3, 0, 2, 15, 15, 9, 1'b0, 1'b0);
    run_one(255, 128, 8, 1, 0, 32, 63, 1, 1, 15, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule